// File: doc/BRIEF.md
# Watchdog Timer with Byte-Wide Control Register

This block is a watchdog that asks for a system reset when software fails to service it in time. A single 8-bit control register is written and read over a simple byte-wide register bus with address, write data, a write strobe and combinational read data. The register holds a 3-bit period select, an enable bit, a restart bit that software sets to service the watchdog, and a data pointer bank select bit. The bank select bit does not affect the watchdog. It is passed straight out so that a neighbouring data pointer multiplexer can use it.

The system clock is divided into base ticks of `CYC_PER_TICK` cycles each, which stands for a nominal 16 ms. The period select picks a timeout of 2^rate base ticks, so the timeout doubles at each step from 16 ms up to 2048 ms. When the timeout expires while the watchdog is enabled, the block raises a one-cycle reset request and starts counting again. The interface is plain control and status pins: there is no data stream and no back-pressure. `CYC_PER_TICK` must be at least 2.

Top module: `wdog_sfr`

## Requirements
- R1: The control register decodes at address 0x96. Its fields are the period select `rate` in bits 7:5, the bank select in bit 2 and the enable `run` in bit 0. A read at 0x96 returns the stored fields. After reset the read returns 0x00.
- R2: Writing 1 to bit 1 (restart) restarts the timeout count at the next clock edge. The bit clears itself one cycle after it is written and always reads as 0. The register's reset image is 0x02, so a restart is pending during the first cycle after reset.
- R3: Bits 4 and 3 ignore writes and always read as 0.
- R4: A write to any address other than 0x96 changes nothing, and does not disturb a running count. A read from any other address returns 0x00.
- R5: When a write sets `run` without restarting the count, the first reset request rises `CYC_PER_TICK * 2^rate` clock edges after that write edge.
- R6: The reset request stays high for exactly one cycle. The count then restarts by itself, so requests repeat every `CYC_PER_TICK * 2^rate` cycles while the block is enabled and not serviced.
- R7: While `run` is 0, the count is held at zero and no reset request is raised.
- R8: A write that changes `rate` restarts the count at the next edge. The new period then runs in full from that edge.
- R9: The output `dptr_bank` follows register bit 2 (0 selects pointer bank 0, 1 selects bank 1) from the edge that writes it.
- R10: If a restart or a rate change takes effect on the same edge as an expiry, the restart wins: no reset request is raised on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Write strobe, one cycle per write |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| dptr_bank | output | 1 | Data pointer bank select |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest case to reach from the ports is a restart that lands on the very edge on which the count would expire. It needs a write whose edge sits exactly one cycle before a known expiry. The stimulus gets there by using a completed reset request as a time reference and then scheduling the restart write against the bench's edge counter. The expected next request is then placed one full period after the restart rather than at the missed expiry. A rate change in the middle of a period is timed the same way. Any request at the old period's expiry edge is reported as unexpected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RATE_W = 3;
  localparam int RATE_LSB = 5;
  localparam int BANK_BIT = 2;
  localparam int KICK_BIT = 1;
  localparam int RUN_BIT = 0;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic bank;
    logic run;
  } wdog_ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output wdog_ctl_t         ctl,
  output logic              kick,
  output logic [DATA_W-1:0] rdata
);
  logic hit_wr;
  logic sel;
  wdog_ctl_t ctl_q;
  logic kick_q;

  assign sel = (bus_addr == REG_ADDR);
  assign hit_wr = bus_we && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      kick_q <= 1'b1;
    end else begin
      kick_q <= hit_wr && bus_wdata[KICK_BIT];
      if (hit_wr) begin
        ctl_q.rate <= bus_wdata[RATE_LSB +: RATE_W];
        ctl_q.bank <= bus_wdata[BANK_BIT];
        ctl_q.run  <= bus_wdata[RUN_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[RATE_LSB +: RATE_W] = ctl_q.rate;
      rdata[BANK_BIT] = ctl_q.bank;
      rdata[RUN_BIT] = ctl_q.run;
    end
  end

  assign ctl = ctl_q;
  assign kick = kick_q;

  AST_KICK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && !(hit_wr && bus_wdata[KICK_BIT])) |=> !kick_q); // R2
  AST_FOREIGN_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !sel) |=> $stable(ctl_q)); // R4
  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[4:3] == 2'b00) && !rdata[KICK_BIT]); // R3
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int CYC_PER_TICK = 3200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CYC_PER_TICK > 1) ? $clog2(CYC_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_TICK - 1);

  logic [CW-1:0] cnt;
  logic at_last;

  assign at_last = (cnt == LAST);
  assign tick = en && !clr && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || !en) begin
      cnt <= '0;
    end else if (at_last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
  AST_TICK_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R7
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PS_W = RATE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] rate,
  input  logic            kick,
  input  logic            tick,
  output logic            clr,
  output logic            bark
);
  localparam int CNT_W = 1 << PS_W;

  logic [PS_W-1:0] rate_prev;
  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] limit;
  logic rate_chg;
  logic expire;
  logic bark_q;

  assign rate_chg = (rate != rate_prev);
  assign clr = kick || rate_chg || !run;
  assign limit = (CNT_W'(1) << rate) - 1'b1;
  assign expire = tick && run && (tick_cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_prev <= '0;
      tick_cnt  <= '0;
      bark_q    <= 1'b0;
    end else begin
      rate_prev <= rate;
      bark_q    <= expire && !clr;
      if (clr || expire) begin
        tick_cnt <= '0;
      end else if (tick) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  assign bark = bark_q;

  AST_BARK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bark_q |=> !bark_q); // R6
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !bark_q); // R7
  AST_OFF_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tick_cnt == '0)); // R7
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick || rate_chg) |=> (!bark_q && tick_cnt == '0)); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= limit || rate_chg); // R8
endmodule

// File: rtl/wdog_sfr.sv
module wdog_sfr
  import wdog_pkg::*;
#(
  parameter int CYC_PER_TICK = 3200000,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              dptr_bank,
  output logic              wdt_reset_req
);
  wdog_ctl_t ctl;
  logic kick;
  logic tick;
  logic clr;

  wdog_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .REG_ADDR(REG_ADDR)
  ) u_regs (
    .clk(clk),
    .rst_n(rst_n),
    .bus_addr(sfr_addr),
    .bus_wdata(sfr_wdata),
    .bus_we(sfr_we),
    .ctl(ctl),
    .kick(kick),
    .rdata(sfr_rdata)
  );

  wdog_tick #(
    .CYC_PER_TICK(CYC_PER_TICK)
  ) u_tick (
    .clk(clk),
    .rst_n(rst_n),
    .en(ctl.run),
    .clr(clr),
    .tick(tick)
  );

  wdog_core #(
    .PS_W(RATE_W)
  ) u_core (
    .clk(clk),
    .rst_n(rst_n),
    .run(ctl.run),
    .rate(ctl.rate),
    .kick(kick),
    .tick(tick),
    .clr(clr),
    .bark(wdt_reset_req)
  );

  assign dptr_bank = ctl.bank;

  AST_BANK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == REG_ADDR) |=> (dptr_bank == $past(sfr_wdata[BANK_BIT]))); // R9
endmodule

// File: tb/wdog_sfr_tb.sv
`timescale 1ns/1ps
module wdog_sfr_tb;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic dptr_bank;
  logic wdt_reset_req;

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  wdog_sfr #(.CYC_PER_TICK(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .dptr_bank(dptr_bank),
    .wdt_reset_req(wdt_reset_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_n);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sfr_we = 1'b0;
    edge_n = cyc_n;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    sfr_addr = a;
    #1;
    chk(req, int'(sfr_rdata), exp);
  endtask

  task automatic wait_to(input int e);
    while (cyc_n < e) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare each reset request with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && wdt_reset_req) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6/R7 unexpected request actual=%0d expected=none", cyc_n);
      end else begin
        chk("R5/R6 request edge", cyc_n, exp_q.pop_front());
      end
    end
    if (cyc_n > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc_n);
      finish_run();
    end
  end

  initial begin
    int w, k, b, r, x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 reset read", 8'h96, 8'h00);
    chk("R9 reset bank", int'(dptr_bank), 0);
    chk("R7 reset no request", int'(wdt_reset_req), 0);

    // rate 0, bank 1, enabled
    wr(8'h96, 8'h05, w);
    rd_chk("R1 readback", 8'h96, 8'h05);
    chk("R9 bank one", int'(dptr_bank), 1);
    exp_q.push_back(w + T); exp_q.push_back(w + 2*T); exp_q.push_back(w + 3*T);
    wait_to(w + 13);
    wr(8'h96, 8'h04, w);           // disable, edge before next expiry
    rd_chk("R7 disabled readback", 8'h96, 8'h04);
    wait_to(w + 40);                // R7: monitor flags any request here

    // rate 2 (period 16); rate change restarts one edge later
    wr(8'h96, 8'h41, w);
    chk("R9 bank zero", int'(dptr_bank), 0);
    exp_q.push_back(w + 1 + 16); exp_q.push_back(w + 1 + 32);
    wait_to(w + 34);
    for (int i = 0; i < 6; i++) begin   // R2: servicing keeps it quiet
      wr(8'h96, 8'h43, k);
      if (i == 0) rd_chk("R2 restart bit reads zero", 8'h96, 8'h41);
      wait_to(k + 9);
    end
    b = k + 1 + 16;
    exp_q.push_back(b);
    wait_to(b + 14);
    wr(8'h96, 8'h43, k);           // R10: restart lands on expiry edge b+16
    chk("R10 restart edge", k, b + 15);
    exp_q.push_back(b + 32);
    wait_to(b + 40);

    // R8: change rate mid-period; old expiry at b+48 must not occur
    wr(8'h96, 8'h61, r);
    exp_q.push_back(r + 1 + 32);
    wait_to(r + 36);

    // R3: reserved bits ignored; rate 7 (period 512)
    wr(8'h96, 8'hF9, r);
    rd_chk("R3 reserved bits read zero", 8'h96, 8'hE1);
    exp_q.push_back(r + 1 + 512);
    wait_to(r + 100);
    wr(8'h95, 8'h00, x);           // R4: foreign write
    rd_chk("R4 foreign read", 8'h95, 8'h00);
    rd_chk("R4 register unchanged", 8'h96, 8'hE1);
    chk("R4 bank unchanged", int'(dptr_bank), 0);
    wait_to(r + 516);

    wr(8'h96, 8'h04, w);
    chk("R9 bank after disable", int'(dptr_bank), 1);
    wait_to(w + 60);
    chk("R5 all expected requests seen", exp_q.size(), 0);
    finish_run();
  end
endmodule